// File: doc/BRIEF.md
# Fixed-Page Descending Stack Pointer

This block produces the data-memory address and write strobe for stack traffic in a small 8-bit processor whose data memory is organised as 16-bit words. Every stack entry takes one whole word. A one-byte register push uses a word, and so does a call, which stores its 16-bit return address in a single entry. The stack sits in the topmost 256-word page of the 16-bit address space. The upper address byte is wired to all ones, and only an 8-bit low pointer moves. After reset the pointer is at the very top of memory. It grows downward as entries are pushed and climbs back as they are popped.

A push or call writes at the current top and then decrements the pointer. A pop or return first increments the pointer and then presents the new address, so the read returns the newest entry. A return takes two processor cycles. In the first cycle the entry is fetched. In the second cycle the program counter raises its halt flag while it fetches the instruction at the returned address. The halt flag stops the pointer from climbing a second time in that cycle. Memory, data steering and stack-depth checking belong to the surrounding datapath.

Top module: `fixed_page_stack_ptr`

## Requirements
- R1: While reset is held and in every idle cycle after reset with no prior stack operation, the address output is 0xFFFF and the write strobe is low.
- R2: The upper eight address bits are 0xFF in every cycle.
- R3: A push request (push_i high, pop_i and ret_i low) raises the write strobe, presents {0xFF, pointer} in the same cycle, and leaves the pointer one lower at the next clock edge.
- R4: A call request behaves exactly like a push: one word is written at {0xFF, pointer} and the pointer drops by one.
- R5: A pop request keeps the write strobe low, presents {0xFF, pointer+1} in the same cycle, and leaves the pointer one higher. A pop right after a push reads the address that push wrote.
- R6: A return whose halt input is low acts as a pop. A following cycle with ret_i and pc_halt_i both high presents the same address with the write strobe low and leaves the pointer unchanged.
- R7: The low pointer wraps modulo 256. A push at 0x00 moves it to 0xFF, and a pop at 0xFF reads address 0xFF00. No overflow or underflow is flagged.
- R8: The halt input has no effect on push, call or pop. Only the increment of a return is suppressed.
- R9: With no request, the write strobe is low, the address shows {0xFF, pointer}, and the pointer holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Synchronous reset, active low |
| push_i | input | 1 | Register push request |
| pop_i | input | 1 | Register pop request |
| call_i | input | 1 | Call request (return address goes to the stack) |
| ret_i | input | 1 | Return request, held for both return cycles |
| pc_halt_i | input | 1 | Program-counter halt flag, high in the second return cycle |
| stk_addr_o | output | 16 | Stack word address |
| stk_we_o | output | 1 | Stack write strobe |

## Verification
Two functions meet in one cycle here: the return request and the program-counter halt. Both are high in the second return cycle, and the halt must win over the increment the return would otherwise cause. The bench produces this pairing in directed two-cycle returns, at mid-stack and across the wrap point. It also interleaves them randomly with pushes, calls and pops that carry a random halt bit, so the halt meets every other request too. Each cycle the bench compares the address and strobe against a byte-wide reference pointer. It judges a suppressed increment by the address seen in the next cycle and in later pops.

// File: rtl/stkp_pkg.sv
// Shared types for the fixed-page stack pointer.
package stkp_pkg;
    // Resolved stack action for one cycle
    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2,
        OP_HOLD = 2'd3
    } stk_op_e;
endpackage

// File: rtl/stkp_decode.sv
// Decodes the request strobes into one stack action.
// Assumes push and pop are never requested together. Push or call takes
// precedence if that happens. Halt suppresses only the return increment.
module stkp_decode
    import stkp_pkg::*;
(
    input  logic    push_i,
    input  logic    pop_i,
    input  logic    call_i,
    input  logic    ret_i,
    input  logic    halt_i,
    output stk_op_e op_o
);
    // Priority: write requests, then reads, then the halted return cycle
    always_comb begin
        if (push_i || call_i)
            op_o = OP_PUSH;
        else if (pop_i || (ret_i && !halt_i))
            op_o = OP_POP;
        else if (ret_i)
            op_o = OP_HOLD;
        else
            op_o = OP_IDLE;
    end
endmodule

// File: rtl/stkp_ptr_reg.sv
// Holds the movable low part of the stack pointer.
// Resets to all ones, decrements after a push, and increments on a pop.
// Wraps modulo 2**PTR_W without any flag.
module stkp_ptr_reg
    import stkp_pkg::*;
#(
    parameter int PTR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  stk_op_e          op_i,
    output logic [PTR_W-1:0] ptr_o,
    output logic [PTR_W-1:0] ptr_inc_o
);
    localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] ptr_d;

    // Incremented value, shared by next-state logic and address forming
    assign ptr_inc_o = ptr_q + ONE;
    assign ptr_o     = ptr_q;

    // Next pointer value from the resolved action
    always_comb begin
        unique case (op_i)
            OP_PUSH: ptr_d = ptr_q - ONE;
            OP_POP:  ptr_d = ptr_inc_o;
            default: ptr_d = ptr_q;
        endcase
    end

    // Pointer register with synchronous active-low reset to the top
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '1;
        else
            ptr_q <= ptr_d;
    end
endmodule

// File: rtl/stkp_addr_form.sv
// Forms the full stack address from the fixed page and the low pointer.
// Push presents the current top. Pop presents the incremented pointer.
// The page field is built bit by bit as constant ones.
module stkp_addr_form
    import stkp_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int PTR_W  = 8
) (
    input  stk_op_e           op_i,
    input  logic [PTR_W-1:0]  ptr_i,
    input  logic [PTR_W-1:0]  ptr_inc_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              we_o
);
    localparam int PAGE_W = ADDR_W - PTR_W;

    logic [PAGE_W-1:0] page;
    logic [PTR_W-1:0]  low;

    // Fixed page bits tied high
    for (genvar g = 0; g < PAGE_W; g++) begin : g_page
        assign page[g] = 1'b1;
    end

    // Low-byte select: pre-increment for reads, current top otherwise
    always_comb begin
        low  = (op_i == OP_POP) ? ptr_inc_i : ptr_i;
        we_o = (op_i == OP_PUSH);
    end

    assign addr_o = {page, low};
endmodule

// File: rtl/fixed_page_stack_ptr.sv
// Top of the fixed-page descending stack pointer.
// Assumes ret_i is held for both return cycles, with pc_halt_i high in
// the second. Push and pop are never requested together.
module fixed_page_stack_ptr #(
    parameter int ADDR_W = 16,
    parameter int PTR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic              call_i,
    input  logic              ret_i,
    input  logic              pc_halt_i,
    output logic [ADDR_W-1:0] stk_addr_o,
    output logic              stk_we_o
);
    import stkp_pkg::*;

    stk_op_e          op;
    logic [PTR_W-1:0] ptr;
    logic [PTR_W-1:0] ptr_inc;

    stkp_decode u_dec (
        .push_i (push_i),
        .pop_i  (pop_i),
        .call_i (call_i),
        .ret_i  (ret_i),
        .halt_i (pc_halt_i),
        .op_o   (op)
    );

    stkp_ptr_reg #(.PTR_W(PTR_W)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_i      (op),
        .ptr_o     (ptr),
        .ptr_inc_o (ptr_inc)
    );

    stkp_addr_form #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_addr (
        .op_i      (op),
        .ptr_i     (ptr),
        .ptr_inc_i (ptr_inc),
        .addr_o    (stk_addr_o),
        .we_o      (stk_we_o)
    );
endmodule

// File: rtl/stkp_chk.sv
// Port-level checker for the fixed-page stack pointer, attached by bind.
module stkp_chk #(
    parameter int ADDR_W = 16,
    parameter int PTR_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              push_i,
    input logic              pop_i,
    input logic              call_i,
    input logic              ret_i,
    input logic              pc_halt_i,
    input logic [ADDR_W-1:0] stk_addr_o,
    input logic              stk_we_o
);
    logic [PTR_W-1:0] lo;
    logic idle, push_only, pop_only;

    assign lo        = stk_addr_o[PTR_W-1:0];
    assign idle      = !(push_i || pop_i || call_i || ret_i);
    assign push_only = (push_i || call_i) && !pop_i && !ret_i;
    assign pop_only  = pop_i && !push_i && !call_i && !ret_i;

    AST_RESET_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) && idle |-> (stk_addr_o == '1) && !stk_we_o); // R1
    AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        stk_addr_o[ADDR_W-1:PTR_W] == '1); // R2
    AST_PUSH_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        push_only |-> stk_we_o); // R3
    AST_PUSH_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(push_only) && idle |-> lo == $past(lo) - PTR_W'(1)); // R3
    AST_READ_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i || ret_i) && !push_i && !call_i |-> !stk_we_o); // R5
    AST_POP_AFTER_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(push_only) && pop_only |-> stk_addr_o == $past(stk_addr_o)); // R5
    AST_RET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(ret_i && !pc_halt_i && !push_i && !call_i) && ret_i && pc_halt_i
        && !push_i && !call_i && !pop_i |-> $stable(stk_addr_o)); // R6
endmodule

bind fixed_page_stack_ptr stkp_chk #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_i     (push_i),
    .pop_i      (pop_i),
    .call_i     (call_i),
    .ret_i      (ret_i),
    .pc_halt_i  (pc_halt_i),
    .stk_addr_o (stk_addr_o),
    .stk_we_o   (stk_we_o)
);

// File: tb/tb_fixed_page_stack_ptr.sv
`timescale 1ns/1ps
module tb_fixed_page_stack_ptr;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_i = 0, pop_i = 0, call_i = 0, ret_i = 0, pc_halt_i = 0;
    logic [15:0] stk_addr_o;
    logic        stk_we_o;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    logic [7:0]  mptr;
    bit          done = 0;

    always #4 clk = ~clk;

    fixed_page_stack_ptr dut (
        .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
        .call_i(call_i), .ret_i(ret_i), .pc_halt_i(pc_halt_i),
        .stk_addr_o(stk_addr_o), .stk_we_o(stk_we_o)
    );

    function automatic logic is_wr(input bit pu, input bit ca);
        return pu | ca;
    endfunction

    function automatic logic is_rd(input bit pu, input bit po, input bit ca,
                                   input bit re, input bit ha);
        return !(pu | ca) && (po | (re & !ha));
    endfunction

    function automatic logic [15:0] f_addr(input logic [7:0] p, input bit pu, input bit po,
                                           input bit ca, input bit re, input bit ha);
        return {8'hFF, is_rd(pu, po, ca, re, ha) ? p + 8'd1 : p};
    endfunction

    function automatic logic [7:0] f_next(input logic [7:0] p, input bit pu, input bit po,
                                          input bit ca, input bit re, input bit ha);
        if (is_wr(pu, ca)) return p - 8'd1;
        if (is_rd(pu, po, ca, re, ha)) return p + 8'd1;
        return p;
    endfunction

    task automatic check(input string req, input logic [15:0] ea, input logic ew);
        n_chk++;
        if (stk_addr_o !== ea || stk_we_o !== ew) begin
            n_bad++;
            $display("FAIL %s: addr=%h we=%b expected addr=%h we=%b", req, stk_addr_o, stk_we_o, ea, ew);
        end
    endtask

    // One cycle: drive after negedge, check mid-cycle, model updates at posedge
    task automatic step(input string req, input bit pu, input bit po, input bit ca,
                        input bit re, input bit ha);
        @(negedge clk);
        push_i = pu; pop_i = po; call_i = ca; ret_i = re; pc_halt_i = ha;
        #1;
        check(req, f_addr(mptr, pu, po, ca, re, ha), is_wr(pu, ca));
        @(posedge clk);
        mptr = f_next(mptr, pu, po, ca, re, ha);
    endtask

    task automatic do_ret(input string req);
        step(req, 0, 0, 0, 1, 0);
        step(req, 0, 0, 0, 1, 1);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        mptr = 8'hFF;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        check("R1 in reset", 16'hFFFF, 1'b0);
        rst_n = 1'b1;
        step("R1 idle after reset", 0, 0, 0, 0, 0);
        step("R9 idle holds", 0, 0, 0, 0, 0);
        // R3 push then R5 pop returns same word
        step("R3 push", 1, 0, 0, 0, 0);
        step("R3 push", 1, 0, 0, 0, 0);
        step("R9 idle after push", 0, 0, 0, 0, 0);
        step("R5 pop", 0, 1, 0, 0, 0);
        // R4 call then R6 two-cycle return
        step("R4 call", 0, 0, 1, 0, 0);
        do_ret("R6 return");
        step("R6 idle after return", 0, 0, 0, 0, 0);
        // R8 halt with push and pop
        step("R8 push with halt", 1, 0, 0, 0, 1);
        step("R8 pop with halt", 0, 1, 0, 0, 1);
        step("R5 pop", 0, 1, 0, 0, 0);
        // R7 pop wrap at top, then push back across
        step("R7 pop wrap", 0, 1, 0, 0, 0);
        step("R7 push wrap", 1, 0, 0, 0, 0);
        // R7 push through whole page and back across 0x00
        for (int i = 0; i < 258; i++) step("R7 push sweep", 1, 0, 0, 0, 0);
        for (int i = 0; i < 4; i++) do_ret("R6 R7 return near wrap");
        // Random mix
        for (int i = 0; i < 3000; i++) begin
            int unsigned k;
            bit h;
            k = $urandom_range(0, 5);
            h = 1'($urandom_range(0, 1));
            case (k)
                0: step("R9 rand idle", 0, 0, 0, 0, h);
                1: step("R3 R8 rand push", 1, 0, 0, 0, h);
                2: step("R5 R8 rand pop", 0, 1, 0, 0, h);
                3: step("R4 R8 rand call", 0, 0, 1, 0, h);
                default: do_ret("R6 rand return");
            endcase
        end
        @(negedge clk);
        push_i = 0; pop_i = 0; call_i = 0; ret_i = 0; pc_halt_i = 0;
        #1;
        check("R2 final page", {8'hFF, mptr}, 1'b0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule